// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block sits on the host side of an asynchronous 8-bit NAND flash bus and carries out one page program per request. A request names a row (block and page), a starting column and a byte count. The sequencer then drives the bus through five steps. It writes a setup command, then four address bytes. It streams the data bytes from a valid/ready byte interface and writes a confirm command. It then waits for the device's ready line to fall and rise again, reads the status byte, and reports the result as a one-cycle completion pulse.

Before any bus activity, each request is checked against three rules. The column range must fit in one page. Pages inside a block must be programmed in ascending order. A page may take at most four partial programs between erases. A request that breaks a rule produces no bus activity. It completes on the next cycle with an error code. An erase-done input tells the block that a block was erased, and clears that block's tracking state.

Both streams use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the sequencer is idle. A data byte is taken on a cycle where `dat_valid` and `dat_ready` are both high. While `dat_valid` is low the bus stays quiet and the sequencer waits. `dat_ready` never depends on `dat_valid`.

Top module: `nand_prog_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, the bus rests with both latch enables low, both strobes high and the data bus not driven. After reset, `req_ready` is high and `dat_ready` is low.
- R2: An accepted, rule-clean request first performs one write strobe with `bus_cmd_latch` high and the byte 80h.
- R3: Four write strobes with `bus_addr_latch` high follow the setup command, in this order: column low byte, column high byte, row low byte, row high byte.
- R4: Next come exactly `req_len` data write strobes, with both latch enables low. They carry the stream bytes in arrival order. A gap in `dat_valid` adds no strobe, and `dat_ready` is high only in the data phase.
- R5: The data is followed by one command write strobe carrying 10h. It is never issued unless at least one data byte was written in the same program.
- R6: After the confirm, the block waits for `bus_rdy` to fall and rise. It then writes command 70h and performs exactly one read strobe. The captured byte appears on `done_stat`, and its bit 0 appears on `done_fail`, with `done_err` = 0.
- R7: A request with `req_len` = 0, or with `req_col` + `req_len` > 2112, is rejected with `done_err` = 3. There is no bus strobe, and `done_valid` rises in the cycle after acceptance.
- R8: A request is rejected with `done_err` = 2 if its page index is lower than the last page accepted in the same block since that block's last erase.
- R9: At most four programs to the same page are accepted between erases. The fifth is rejected with `done_err` = 1. Rejected requests do not count.
- R10: A pulse on `ers_valid` clears the page counters and the last-page record of block `ers_blk` only. Other blocks keep their state.
- R11: When several rules fail, the error code is chosen by priority: length (3) first, then order (2), then limit (1). `req_ready` is low for the whole time `busy` is high.
- R12: The page index is `req_row[2:0]` and the block index is `req_row[4:3]`. The full 16-bit row is sent on the bus unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken when both high (idle only) |
| req_row | input | 16 | Row address: block and page |
| req_col | input | 12 | Starting column |
| req_len | input | 12 | Number of data bytes |
| dat_valid | input | 1 | Data byte offered |
| dat_ready | output | 1 | Data byte taken when both high |
| dat_byte | input | 8 | Data byte |
| ers_valid | input | 1 | One-cycle pulse: a block was erased |
| ers_blk | input | 2 | Index of the erased block |
| busy | output | 1 | Sequencer not idle |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 2 | 0 ok, 1 page limit, 2 order, 3 length |
| done_fail | output | 1 | Device status bit 0 (1 = program failed) |
| done_stat | output | 8 | Full status byte read from the device |
| bus_cmd_latch | output | 1 | Command latch enable |
| bus_addr_latch | output | 1 | Address latch enable |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_dq_out | output | 8 | Byte driven to the device |
| bus_dq_oe | output | 1 | Drive enable for `bus_dq_out` |
| bus_dq_in | input | 8 | Byte from the device |
| bus_rdy | input | 1 | Device ready (low while busy), asynchronous |

## Verification
Any corruption of the per-page counters or the last-page records shows up only when a later request reaches that page or block. There it appears as a wrong `done_err` in the cycle right after acceptance, so the bench sweeps every page of every block past its limit and steps back one page to reach those cases. A broken sequencing state shows within one program. It appears as a missing, extra or misordered strobe in the captured bus log, a status read before the ready line recovers, or a completion that never arrives.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_DATA = 2'd2,
    KIND_READ = 2'd3
  } bus_kind_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_LIMIT = 2'd1,
    ERR_ORDER = 2'd2,
    ERR_LEN   = 2'd3
  } prog_err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ADDR, S_DATA, S_CONFIRM,
    S_WAIT_LOW, S_WAIT_HIGH, S_STAT_CMD, S_STAT_RD, S_STAT_WAIT, S_DONE
  } seq_state_e;

  localparam logic [7:0] OP_SETUP   = 8'h80;
  localparam logic [7:0] OP_CONFIRM = 8'h10;
  localparam logic [7:0] OP_STATUS  = 8'h70;

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_seq_pkg::*;
#(
  parameter int LOW_CYC  = 1,
  parameter int HIGH_CYC = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  bus_kind_e  kind,
  input  logic [7:0] wbyte,
  output logic       free,
  output logic       done,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic       dq_oe,
  output logic [7:0] dq_out,
  input  logic [7:0] dq_in,
  output logic [7:0] rd_byte
);

  localparam int MAXC   = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_CYC - 1);

  logic             busy_q, low_q;
  logic [CNT_W-1:0] cnt_q;
  bus_kind_e        kind_q;
  logic [7:0]       byte_q, rd_q;

  // A cycle finishes at the end of its strobe-high phase; a new one may
  // start on that same edge, so cycles run back to back.
  assign done = busy_q && !low_q && (cnt_q == HIGH_LAST);
  assign free = !busy_q || done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      low_q  <= 1'b0;
      cnt_q  <= '0;
      kind_q <= KIND_CMD;
      byte_q <= '0;
      rd_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      low_q  <= 1'b1;
      cnt_q  <= '0;
      kind_q <= kind;
      byte_q <= wbyte;
    end else if (busy_q) begin
      if (low_q) begin
        if (cnt_q == LOW_LAST) begin
          low_q <= 1'b0;
          cnt_q <= '0;
          if (kind_q == KIND_READ) rd_q <= dq_in;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cnt_q == HIGH_LAST) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cle     = busy_q && (kind_q == KIND_CMD);
  assign ale     = busy_q && (kind_q == KIND_ADDR);
  assign we_n    = !(busy_q && low_q && (kind_q != KIND_READ));
  assign re_n    = !(busy_q && low_q && (kind_q == KIND_READ));
  assign dq_oe   = busy_q && (kind_q != KIND_READ);
  assign dq_out  = byte_q;
  assign rd_byte = rd_q;

  // R4: the sequencer only launches a cycle when the unit can take it.
  p_start_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> free);
  // R3: command and address latches never overlap.
  p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cle, ale}));
  // R6: read and write strobes never overlap.
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_n || re_n);

endmodule

// File: rtl/nand_rule_table.sv
module nand_rule_table #(
  parameter int N_BLOCKS = 4,
  parameter int PAGES    = 8,
  localparam int BLK_W   = $clog2(N_BLOCKS),
  localparam int PAGE_W  = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  chk_blk,
  input  logic [PAGE_W-1:0] chk_page,
  input  logic              commit,
  input  logic              ers_valid,
  input  logic [BLK_W-1:0]  ers_blk,
  output logic              order_bad,
  output logic              limit_bad
);

  localparam int          N_ENTRIES = N_BLOCKS * PAGES;
  localparam logic [2:0]  CNT_MAX   = 3'd4;

  logic [2:0]        cnt_all  [N_ENTRIES];
  logic [PAGE_W-1:0] last_all [N_BLOCKS];
  logic              used_all [N_BLOCKS];

  for (genvar gb = 0; gb < N_BLOCKS; gb++) begin : g_blk
    logic              hit_ers, hit_com;
    logic [PAGE_W-1:0] last_q;
    logic              used_q;

    assign hit_ers = ers_valid && (ers_blk == BLK_W'(gb));
    assign hit_com = commit && (chk_blk == BLK_W'(gb));

    always_ff @(posedge clk) begin
      if (!rst_n || hit_ers) begin
        last_q <= '0;
        used_q <= 1'b0;
      end else if (hit_com) begin
        last_q <= chk_page;
        used_q <= 1'b1;
      end
    end
    assign last_all[gb] = last_q;
    assign used_all[gb] = used_q;

    // R10: an erase wipes this block's page order record.
    p_erase_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ers |=> !used_q);

    for (genvar gp = 0; gp < PAGES; gp++) begin : g_pg
      logic [2:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n || hit_ers)
          cnt_q <= '0;
        else if (hit_com && chk_page == PAGE_W'(gp))
          cnt_q <= cnt_q + 1'b1;
      end
      assign cnt_all[gb*PAGES + gp] = cnt_q;

      // R9: a page counter never passes the partial-program limit.
      p_cnt_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
      // R10: an erase leaves every page of the block at zero.
      p_erase_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ers |=> cnt_q == 3'd0);
    end
  end

  assign order_bad = used_all[chk_blk] && (chk_page < last_all[chk_blk]);
  assign limit_bad = cnt_all[{chk_blk, chk_page}] >= CNT_MAX;

endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq
  import nand_seq_pkg::*;
#(
  parameter int N_BLOCKS        = 4,
  parameter int PAGES_PER_BLOCK = 8,
  parameter int PAGE_BYTES      = 2112,
  parameter int COL_W           = 12,
  parameter int ROW_W           = 16,
  parameter int LOW_CYC         = 1,
  parameter int HIGH_CYC        = 1,
  parameter int SYNC_STAGES     = 2,
  localparam int BLK_W          = $clog2(N_BLOCKS),
  localparam int PAGE_W         = $clog2(PAGES_PER_BLOCK),
  localparam int LEN_W          = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [LEN_W-1:0] req_len,
  input  logic             dat_valid,
  output logic             dat_ready,
  input  logic [7:0]       dat_byte,
  input  logic             ers_valid,
  input  logic [BLK_W-1:0] ers_blk,
  output logic             busy,
  output logic             done_valid,
  output logic [1:0]       done_err,
  output logic             done_fail,
  output logic [7:0]       done_stat,
  output logic             bus_cmd_latch,
  output logic             bus_addr_latch,
  output logic             bus_wr_n,
  output logic             bus_rd_n,
  output logic [7:0]       bus_dq_out,
  output logic             bus_dq_oe,
  input  logic [7:0]       bus_dq_in,
  input  logic             bus_rdy
);

  localparam int SUM_W = ((COL_W > LEN_W) ? COL_W : LEN_W) + 1;

  seq_state_e              state_q;
  logic [1:0]              aidx_q;
  logic [LEN_W-1:0]        remain_q;
  logic [COL_W-1:0]        col_q;
  logic [ROW_W-1:0]        row_q;
  prog_err_e               err_q;
  logic [7:0]              stat_q;
  logic                    data_seen_q;
  logic [SYNC_STAGES-1:0]  rdy_sync_q;
  logic                    rdy_s;

  logic       accept, commit, len_bad, order_bad, limit_bad;
  prog_err_e  verdict;
  logic [SUM_W-1:0] col_end;
  logic       cyc_start, cyc_free, cyc_done;
  bus_kind_e  cyc_kind;
  logic [7:0] cyc_byte, rd_byte;
  logic [15:0] col16, row16;

  // ---------------- request verdict ----------------
  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign col_end   = SUM_W'(req_col) + SUM_W'(req_len);
  assign len_bad   = (req_len == '0) || (col_end > SUM_W'(PAGE_BYTES));

  always_comb begin
    if (len_bad)        verdict = ERR_LEN;
    else if (order_bad) verdict = ERR_ORDER;
    else if (limit_bad) verdict = ERR_LIMIT;
    else                verdict = ERR_NONE;
  end
  assign commit = accept && (verdict == ERR_NONE);

  nand_rule_table #(
    .N_BLOCKS (N_BLOCKS),
    .PAGES    (PAGES_PER_BLOCK)
  ) u_rules (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_blk   (req_row[PAGE_W +: BLK_W]),
    .chk_page  (req_row[PAGE_W-1:0]),
    .commit    (commit),
    .ers_valid (ers_valid),
    .ers_blk   (ers_blk),
    .order_bad (order_bad),
    .limit_bad (limit_bad)
  );

  // ---------------- bus cycle launch ----------------
  assign col16 = 16'(col_q);
  assign row16 = 16'(row_q);

  always_comb begin
    cyc_start = 1'b0;
    cyc_kind  = KIND_CMD;
    cyc_byte  = 8'h00;
    dat_ready = 1'b0;
    unique case (state_q)
      S_SETUP: begin
        cyc_start = cyc_free;
        cyc_byte  = OP_SETUP;
      end
      S_ADDR: begin
        cyc_start = cyc_free;
        cyc_kind  = KIND_ADDR;
        unique case (aidx_q)
          2'd0:    cyc_byte = col16[7:0];
          2'd1:    cyc_byte = col16[15:8];
          2'd2:    cyc_byte = row16[7:0];
          default: cyc_byte = row16[15:8];
        endcase
      end
      S_DATA: begin
        dat_ready = cyc_free;
        cyc_start = cyc_free && dat_valid;
        cyc_kind  = KIND_DATA;
        cyc_byte  = dat_byte;
      end
      S_CONFIRM: begin
        cyc_start = cyc_free;
        cyc_byte  = OP_CONFIRM;
      end
      S_STAT_CMD: begin
        cyc_start = cyc_free;
        cyc_byte  = OP_STATUS;
      end
      S_STAT_RD: begin
        cyc_start = cyc_free;
        cyc_kind  = KIND_READ;
      end
      default: ;
    endcase
  end

  nand_bus_cycle #(
    .LOW_CYC  (LOW_CYC),
    .HIGH_CYC (HIGH_CYC)
  ) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (cyc_start),
    .kind    (cyc_kind),
    .wbyte   (cyc_byte),
    .free    (cyc_free),
    .done    (cyc_done),
    .cle     (bus_cmd_latch),
    .ale     (bus_addr_latch),
    .we_n    (bus_wr_n),
    .re_n    (bus_rd_n),
    .dq_oe   (bus_dq_oe),
    .dq_out  (bus_dq_out),
    .dq_in   (bus_dq_in),
    .rd_byte (rd_byte)
  );

  // ---------------- ready line synchronizer ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) rdy_sync_q <= '1;
    else        rdy_sync_q <= {rdy_sync_q[SYNC_STAGES-2:0], bus_rdy};
  end
  assign rdy_s = rdy_sync_q[SYNC_STAGES-1];

  // ---------------- sequence ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      aidx_q      <= '0;
      remain_q    <= '0;
      col_q       <= '0;
      row_q       <= '0;
      err_q       <= ERR_NONE;
      stat_q      <= '0;
      data_seen_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          col_q       <= req_col;
          row_q       <= req_row;
          remain_q    <= req_len;
          aidx_q      <= '0;
          err_q       <= verdict;
          stat_q      <= '0;
          data_seen_q <= 1'b0;
          state_q     <= (verdict == ERR_NONE) ? S_SETUP : S_DONE;
        end
        S_SETUP: if (cyc_start) state_q <= S_ADDR;
        S_ADDR: if (cyc_start) begin
          aidx_q <= aidx_q + 1'b1;
          if (aidx_q == 2'd3) state_q <= S_DATA;
        end
        S_DATA: if (cyc_start) begin
          data_seen_q <= 1'b1;
          remain_q    <= remain_q - 1'b1;
          if (remain_q == LEN_W'(1)) state_q <= S_CONFIRM;
        end
        S_CONFIRM:   if (cyc_start) state_q <= S_WAIT_LOW;
        S_WAIT_LOW:  if (!rdy_s) state_q <= S_WAIT_HIGH;
        S_WAIT_HIGH: if (rdy_s) state_q <= S_STAT_CMD;
        S_STAT_CMD:  if (cyc_start) state_q <= S_STAT_RD;
        S_STAT_RD:   if (cyc_start) state_q <= S_STAT_WAIT;
        S_STAT_WAIT: if (cyc_done) begin
          stat_q  <= rd_byte;
          state_q <= S_DONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign done_valid = (state_q == S_DONE);
  assign done_err   = err_q;
  assign done_stat  = stat_q;
  assign done_fail  = stat_q[0];

  // R1: an idle sequencer leaves the bus at rest.
  p_bus_rest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_cmd_latch && !bus_addr_latch && bus_wr_n && bus_rd_n && !bus_dq_oe));
  // R5: the confirm strobe only follows loaded data.
  p_confirm_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_latch && !bus_wr_n && bus_dq_out == OP_CONFIRM) |-> data_seen_q);
  // R6: the status command waits for the ready line to be back high.
  p_status_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_latch && !bus_wr_n && bus_dq_out == OP_STATUS) |-> rdy_s);
  // R7: a rejected request completes on the next cycle with its code.
  p_reject_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && verdict != ERR_NONE) |=> (done_valid && done_err == $past(verdict)));

endmodule

// File: tb/test_nand_prog_seq.sv
`timescale 1ns/1ps
module test_nand_prog_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [15:0] req_row = '0;
  logic [11:0] req_col = '0, req_len = '0;
  logic        dat_valid = 1'b0, dat_ready;
  logic [7:0]  dat_byte = '0;
  logic        ers_valid = 1'b0;
  logic [1:0]  ers_blk = '0;
  logic        busy, done_valid, done_fail;
  logic [1:0]  done_err;
  logic [7:0]  done_stat;
  logic        bus_cmd_latch, bus_addr_latch, bus_wr_n, bus_rd_n, bus_dq_oe;
  logic [7:0]  bus_dq_out, bus_dq_in;
  logic        bus_rdy = 1'b1;
  logic        dev_fail = 1'b0;

  int checks = 0, errors = 0;
  int wr_n = 0, re_cnt = 0;
  int lg_k [64];
  int lg_b [64];
  bit conf_go = 0, rb_done = 0, st_ok = 0, finished = 0;
  int m_cnt [4][8];
  int m_last [4];
  bit m_used [4];

  always #2 clk = ~clk;

  assign bus_dq_in = dev_fail ? 8'hE1 : 8'hE0;

  nand_prog_seq i_nand_prog_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
    .req_col(req_col), .req_len(req_len),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .ers_valid(ers_valid), .ers_blk(ers_blk),
    .busy(busy), .done_valid(done_valid), .done_err(done_err),
    .done_fail(done_fail), .done_stat(done_stat),
    .bus_cmd_latch(bus_cmd_latch), .bus_addr_latch(bus_addr_latch),
    .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_dq_out(bus_dq_out),
    .bus_dq_oe(bus_dq_oe), .bus_dq_in(bus_dq_in), .bus_rdy(bus_rdy)
  );

  // device side: log every write strobe (kind 1 = command, 2 = address, 0 = data)
  always @(posedge bus_wr_n) if (rst_n) begin
    if (wr_n < 64) begin
      lg_k[wr_n] = bus_cmd_latch ? 1 : (bus_addr_latch ? 2 : 0);
      lg_b[wr_n] = int'(bus_dq_out);
    end
    if (bus_cmd_latch && bus_dq_out == 8'h10) conf_go = 1;
    if (bus_cmd_latch && bus_dq_out == 8'h70) st_ok = rb_done && bus_rdy;
    wr_n++;
  end

  always @(negedge bus_rd_n) if (rst_n) re_cnt++;

  initial forever begin
    @(negedge clk);
    if (conf_go) begin
      conf_go = 0;
      repeat (2) @(negedge clk);
      bus_rdy = 1'b0;
      repeat (8) @(negedge clk);
      bus_rdy = 1'b1;
      rb_done = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model(input int b, input int p, input int col, input int len);
    if (len == 0 || col + len > 2112) return 3;
    if (m_used[b] && p < m_last[b]) return 2;
    if (m_cnt[b][p] >= 4) return 1;
    m_cnt[b][p]++;
    m_last[b] = p;
    m_used[b] = 1;
    return 0;
  endfunction

  function automatic int pat(input int row, input int col, input int i);
    return (row * 7 + i * 13 + col) & 8'hFF;
  endfunction

  task automatic do_prog(input int b, input int p, input int col, input int len,
                         input bit fbit, input bit chk_busy);
    int row = b * 8 + p;
    int exp = model(b, p, col, len);
    int re0 = re_cnt;
    int bad_s = 0, bad_a = 0, bad_d = 0, bad_c = 0, g = 0;
    wr_n = 0; rb_done = 0; st_ok = 0; dev_fail = fbit;
    @(negedge clk);
    req_valid = 1'b1; req_row = 16'(row); req_col = 12'(col); req_len = 12'(len);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp != 0) begin
      chk(done_valid == 1'b1, "R7", "reject completes next cycle", int'(done_valid), 1);
      chk(int'(done_err) == exp, exp == 3 ? "R7" : (exp == 2 ? "R8" : "R9"),
          "error code", int'(done_err), exp);
      @(negedge clk);
      chk(wr_n == 0 && re_cnt == re0, "R11", "no bus strobe on reject", wr_n, 0);
      return;
    end
    for (int i = 0; i < len; i++) begin
      dat_valid = 1'b1; dat_byte = 8'(pat(row, col, i));
      while (!dat_ready) @(negedge clk);
      @(negedge clk);
      if (i == 0 && chk_busy)
        chk(busy && !req_ready, "R11", "req_ready low while busy", int'(req_ready), 0);
      if (i % 2 == 1) begin
        dat_valid = 1'b0;
        @(negedge clk);
      end
    end
    dat_valid = 1'b0;
    while (!done_valid && g < 5000) begin @(negedge clk); g++; end
    chk(done_valid == 1'b1, "R6", "completion pulse", int'(done_valid), 1);
    chk(done_err == 2'd0, "R6", "ok code", int'(done_err), 0);
    chk(done_fail == fbit && done_stat == (fbit ? 8'hE1 : 8'hE0), "R6",
        "status byte", int'(done_stat), fbit ? 'hE1 : 'hE0);
    chk(re_cnt == re0 + 1, "R6", "one read strobe", re_cnt - re0, 1);
    chk(st_ok, "R6", "status after ready cycle", int'(st_ok), 1);
    chk(wr_n == len + 7, "R4", "write strobe count", wr_n, len + 7);
    if (wr_n == len + 7) begin
      if (lg_k[0] != 1 || lg_b[0] != 'h80) bad_s++;
      if (lg_k[1] != 2 || lg_b[1] != (col & 'hFF)) bad_a++;
      if (lg_k[2] != 2 || lg_b[2] != (col >> 8)) bad_a++;
      if (lg_k[3] != 2 || lg_b[3] != (row & 'hFF)) bad_a++;
      if (lg_k[4] != 2 || lg_b[4] != (row >> 8)) bad_a++;
      for (int i = 0; i < len; i++)
        if (lg_k[5+i] != 0 || lg_b[5+i] != pat(row, col, i)) bad_d++;
      if (lg_k[5+len] != 1 || lg_b[5+len] != 'h10) bad_c++;
      if (lg_k[6+len] != 1 || lg_b[6+len] != 'h70) bad_c++;
    end
    chk(bad_s == 0, "R2", "setup command", bad_s, 0);
    chk(bad_a == 0, "R3 R12", "address bytes", bad_a, 0);
    chk(bad_d == 0, "R4", "data bytes", bad_d, 0);
    chk(bad_c == 0, "R5", "confirm and status command", bad_c, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) begin
      m_last[b] = 0; m_used[b] = 0;
      for (int p = 0; p < 8; p++) m_cnt[b][p] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && req_ready && !dat_ready && !done_valid, "R1", "idle handshake",
        int'(busy), 0);
    chk(!bus_cmd_latch && !bus_addr_latch && bus_wr_n && bus_rd_n && !bus_dq_oe,
        "R1", "bus at rest", int'(bus_wr_n), 1);

    // length rules and the page-end boundary
    do_prog(3, 0, 0, 0, 0, 0);
    do_prog(3, 0, 2100, 13, 0, 0);
    do_prog(3, 0, 2100, 12, 0, 1);
    chk(!bus_cmd_latch && !bus_addr_latch && bus_wr_n && bus_rd_n, "R1",
        "bus at rest after program", int'(bus_wr_n), 1);

    // sweep: every page, five attempts each, then one step backward
    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 8; p++) begin
        for (int a = 0; a < 5; a++)
          do_prog(b, p, a * 4, 1 + (a + p) % 3, a == 2, 0);
        if (p > 0) do_prog(b, p - 1, 0, 1, 0, 0);   // R11: order outranks limit
      end
    do_prog(0, 0, 0, 0, 0, 0);   // R11: length outranks order and limit

    // R10 R12: erase block 1 only
    @(negedge clk);
    ers_valid = 1'b1; ers_blk = 2'd1;
    @(negedge clk);
    ers_valid = 1'b0;
    m_used[1] = 0; m_last[1] = 0;
    for (int p = 0; p < 8; p++) m_cnt[1][p] = 0;
    do_prog(1, 0, 8, 2, 0, 0);
    chk(done_err == 2'd0, "R10", "erased block accepts page 0", int'(done_err), 0);
    do_prog(1, 3, 0, 3, 1, 0);
    do_prog(1, 2, 0, 1, 0, 0);
    do_prog(2, 0, 0, 1, 0, 0);
    chk(done_err == 2'd2, "R10", "other block keeps order", int'(done_err), 2);
    do_prog(2, 7, 0, 1, 0, 0);
    chk(done_err == 2'd1, "R12", "other block keeps counts", int'(done_err), 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule